// File: doc/BRIEF.md
# Assertion Halt Monitor

This block sits beside a design under test that runs under a target-time model. The design turns each of its runtime checks into a combinational fire signal. Each fire signal has an enable bit beside it. The monitor watches all of these signals, but only on cycles where a target-cycle token is consumed. Its checking therefore stays exact in target time, however many host clocks pass between tokens.

The monitor also keeps a target cycle counter, which moves only on accepted advance strobes. When an enabled fire signal is high during an accepted advance, the monitor raises a sticky halt. It stores the numeric ID of the check that fired and the target cycle in which it fired. If more than one check fired in that cycle, it lowers no other flag but sets a flag for that case.

While halt is high, every further advance strobe is refused. The design under test is frozen, and software can read the stored report at leisure. A pulse on the clear input releases the halt and wipes the report. The target cycle counter keeps its value.

Top module: `assert_halt_monitor`

## Requirements
- R1: While reset is asserted, and for two clock edges after it is released, every output is zero and fire conditions are ignored.
- R2: The target cycle output `tcycle_o` increases by exactly one on each accepted advance and wraps to zero after 2^CYC_W-1. It holds its value on every other cycle.
- R3: An advance strobe is accepted only when the monitor is not halted. `step_o` is high in exactly the clock cycle of an accepted advance.
- R4: If an accepted advance finds any bit of `fire_i & enable_i` high, `halt_o` is 1 from the next clock edge.
- R5: On capture, `fired_id_o` holds the lowest bit index i for which both `fire_i[i]` and `enable_i[i]` are 1, encoded as an unsigned binary number.
- R6: On capture, `fired_cycle_o` holds the value that `tcycle_o` had during the advance that fired. This is the count before that advance's increment.
- R7: On capture, `multi_o` is 1 exactly when two or more bits of `fire_i & enable_i` were high.
- R8: A fire bit whose enable bit is low has no effect. The advance is accepted and counted, and no halt follows.
- R9: Fire bits on a cycle without an advance strobe have no effect.
- R10: Halt is sticky. While halted and with no clear pulse, `halt_o`, `fired_id_o`, `fired_cycle_o`, `multi_o` and `tcycle_o` all hold their values.
- R11: A clear pulse while halted sets `halt_o`, `fired_id_o`, `fired_cycle_o` and `multi_o` to zero at the next edge and leaves `tcycle_o` unchanged. A clear pulse while not halted has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fire_i | input | N_CHK | Per-check fire condition; bit i is check ID i |
| enable_i | input | N_CHK | Per-check enable; a low bit masks its fire bit |
| adv_i | input | 1 | Target-cycle advance strobe (token offered) |
| clear_i | input | 1 | Software clear of a pending halt and its report |
| step_o | output | 1 | Advance accepted this cycle (token consumed) |
| halt_o | output | 1 | Sticky halt |
| fired_id_o | output | ID_W | Encoded ID of the reported check |
| fired_cycle_o | output | CYC_W | Target cycle in which the reported check fired |
| multi_o | output | 1 | More than one enabled check fired in that cycle |
| tcycle_o | output | CYC_W | Current target cycle count |

## Verification
With four checks, the bench applies an advance with every combination of the 16 fire patterns and the 16 enable patterns. This separates masking (R8) from lowest-index selection (R5) and from the multiple-fire flag (R7). Each halting vector is followed by blocked advances that carry other fire patterns, and then by a clear. Together these show that the report stays frozen and that clearing does not disturb the counter. Fire patterns are also applied with no advance, which tells token-gated checking apart from checking on every clock. A reduced 8-bit counter is run through its wrap point.

// File: rtl/ahm_pkg.sv
package ahm_pkg;
  // Width of an encoded check ID for n checks (at least one bit).
  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ahm_rst_sync.sv
module ahm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ahm_lowest_enc.sv
module ahm_lowest_enc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] id_o,
  output logic          multi_o
);
  logic          seen;
  logic [IW-1:0] idx;
  logic          many;

  always_comb begin
    seen = 1'b0;
    many = 1'b0;
    idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        if (seen) many = 1'b1;
        else      idx  = IW'(i);
        seen = 1'b1;
      end
    end
  end

  assign any_o   = seen;
  assign id_o    = idx;
  assign multi_o = many;
endmodule

// File: rtl/ahm_tcounter.sv
module ahm_tcounter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/ahm_capture.sv
module ahm_capture #(
  parameter int IW = 3,
  parameter int W  = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [IW-1:0] hit_id_i,
  input  logic          hit_multi_i,
  input  logic [W-1:0]  now_i,
  input  logic          clear_i,
  output logic          halt_o,
  output logic [IW-1:0] id_o,
  output logic [W-1:0]  cyc_o,
  output logic          multi_o
);
  logic          halt_q, halt_d;
  logic [IW-1:0] id_q, id_d;
  logic [W-1:0]  cyc_q, cyc_d;
  logic          multi_q, multi_d;
  logic          load_en;

  always_comb begin
    halt_d  = halt_q;
    id_d    = id_q;
    cyc_d   = cyc_q;
    multi_d = multi_q;
    if (halt_q && clear_i) begin
      halt_d  = 1'b0;
      id_d    = '0;
      cyc_d   = '0;
      multi_d = 1'b0;
    end else if (!halt_q && hit_i) begin
      halt_d  = 1'b1;
      id_d    = hit_id_i;
      cyc_d   = now_i;
      multi_d = hit_multi_i;
    end
  end

  assign load_en = (halt_q && clear_i) || (!halt_q && hit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q  <= 1'b0;
      id_q    <= '0;
      cyc_q   <= '0;
      multi_q <= 1'b0;
    end else if (load_en) begin
      halt_q  <= halt_d;
      id_q    <= id_d;
      cyc_q   <= cyc_d;
      multi_q <= multi_d;
    end
  end

  assign halt_o  = halt_q;
  assign id_o    = id_q;
  assign cyc_o   = cyc_q;
  assign multi_o = multi_q;
endmodule

// File: rtl/assert_halt_monitor.sv
module assert_halt_monitor #(
  parameter int N_CHK = 16,
  parameter int CYC_W = 64,
  parameter int ID_W  = ahm_pkg::id_width(N_CHK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CHK-1:0] fire_i,
  input  logic [N_CHK-1:0] enable_i,
  input  logic             adv_i,
  input  logic             clear_i,
  output logic             step_o,
  output logic             halt_o,
  output logic [ID_W-1:0]  fired_id_o,
  output logic [CYC_W-1:0] fired_cycle_o,
  output logic             multi_o,
  output logic [CYC_W-1:0] tcycle_o
);
  logic             rst_int_n;
  logic [N_CHK-1:0] armed;
  logic             any_hit;
  logic [ID_W-1:0]  low_id;
  logic             many_hit;
  logic             step;
  logic             halted;
  logic [CYC_W-1:0] now;

  ahm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < N_CHK; g++) begin : g_arm
    assign armed[g] = fire_i[g] & enable_i[g];
  end

  ahm_lowest_enc #(.N(N_CHK), .IW(ID_W)) u_enc (
    .vec_i   (armed),
    .any_o   (any_hit),
    .id_o    (low_id),
    .multi_o (many_hit)
  );

  assign step = adv_i && !halted && rst_int_n;

  ahm_tcounter #(.W(CYC_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc_i   (step),
    .count_o (now)
  );

  ahm_capture #(.IW(ID_W), .W(CYC_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .hit_i       (step && any_hit),
    .hit_id_i    (low_id),
    .hit_multi_i (many_hit),
    .now_i       (now),
    .clear_i     (clear_i),
    .halt_o      (halted),
    .id_o        (fired_id_o),
    .cyc_o       (fired_cycle_o),
    .multi_o     (multi_o)
  );

  assign step_o   = step;
  assign halt_o   = halted;
  assign tcycle_o = now;
endmodule

module ahm_chk #(
  parameter int N_CHK = 16,
  parameter int CYC_W = 64,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic [N_CHK-1:0] fire_i,
  input logic [N_CHK-1:0] enable_i,
  input logic             adv_i,
  input logic             clear_i,
  input logic             step_o,
  input logic             halt_o,
  input logic [ID_W-1:0]  fired_id_o,
  input logic [CYC_W-1:0] fired_cycle_o,
  input logic             multi_o,
  input logic [CYC_W-1:0] tcycle_o
);
  // R2
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    step_o |=> tcycle_o == $past(tcycle_o) + CYC_W'(1));
  // R3
  no_step_halted_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    halt_o |-> !step_o);
  // R4
  hit_halts_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_o && |(fire_i & enable_i)) |=> halt_o);
  // R6
  cyc_capture_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step_o && |(fire_i & enable_i)) |=> fired_cycle_o == $past(tcycle_o));
  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halt_o && !clear_i) |=> halt_o && $stable(fired_id_o) && $stable(fired_cycle_o)
                              && $stable(multi_o) && $stable(tcycle_o));
  // R11
  clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (halt_o && clear_i) |=> !halt_o && fired_id_o == '0 && fired_cycle_o == '0
                             && !multi_o && $stable(tcycle_o));
endmodule

bind assert_halt_monitor ahm_chk #(.N_CHK(N_CHK), .CYC_W(CYC_W), .ID_W(ID_W)) u_ahm_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .fire_i        (fire_i),
  .enable_i      (enable_i),
  .adv_i         (adv_i),
  .clear_i       (clear_i),
  .step_o        (step_o),
  .halt_o        (halt_o),
  .fired_id_o    (fired_id_o),
  .fired_cycle_o (fired_cycle_o),
  .multi_o       (multi_o),
  .tcycle_o      (tcycle_o)
);

// File: tb/sim_assert_halt_monitor.sv
module sim_assert_halt_monitor;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  fire, en;
  logic          adv, clr;
  logic          step_o, halt_o, multi_o;
  logic [IW-1:0] id_o;
  logic [CW-1:0] fcyc_o, tcyc_o;

  int vectors = 0;
  int fails   = 0;

  // bench-side model
  logic          m_halt, m_multi;
  logic [IW-1:0] m_id;
  logic [CW-1:0] m_fcyc, m_cnt;

  assert_halt_monitor #(.N_CHK(N), .CYC_W(CW), .ID_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .enable_i(en), .adv_i(adv),
    .clear_i(clr), .step_o(step_o), .halt_o(halt_o), .fired_id_o(id_o),
    .fired_cycle_o(fcyc_o), .multi_o(multi_o), .tcycle_o(tcyc_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " halt"},  64'(halt_o), 64'(m_halt));
    check({req, " id"},    64'(id_o),   64'(m_id));
    check({req, " fcyc"},  64'(fcyc_o), 64'(m_fcyc));
    check({req, " multi"}, 64'(multi_o), 64'(m_multi));
    check({req, " tcyc"},  64'(tcyc_o), 64'(m_cnt));
  endtask

  // One clock of stimulus, driven at negedge, results checked at next negedge.
  task automatic apply(input logic [N-1:0] f, input logic [N-1:0] e,
                       input logic a, input logic c, input string req);
    logic [N-1:0] arm;
    int           ones;
    fire = f; en = e; adv = a; clr = c;
    #1;
    check({req, " step"}, 64'(step_o), 64'(a && !m_halt)); // R3
    arm  = f & e;
    ones = $countones(arm);
    if (m_halt && c) begin
      m_halt = 1'b0; m_id = '0; m_fcyc = '0; m_multi = 1'b0;
    end else if (!m_halt && a) begin
      if (arm != '0) begin
        m_halt  = 1'b1;
        m_fcyc  = m_cnt;
        m_multi = (ones > 1);
        m_id    = '0;
        for (int i = N - 1; i >= 0; i--) if (arm[i]) m_id = IW'(i);
      end
      m_cnt = m_cnt + CW'(1);
    end
    @(negedge clk);
    fire = '0; en = '0; adv = 1'b0; clr = 1'b0;
    check_all(req);
  endtask

  initial begin
    fire = '0; en = '0; adv = 1'b0; clr = 1'b0;
    m_halt = 0; m_id = '0; m_fcyc = '0; m_multi = 0; m_cnt = '0;
    rst_n = 1'b0;
    // R1: fires and advances during reset are ignored
    fire = '1; en = '1; adv = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 step in reset", 64'(step_o), 64'(0));
    fire = '0; en = '0; adv = 1'b0;
    check_all("R1 reset");
    rst_n = 1'b1;
    // two edges for synchronous release
    fire = '1; en = '1; adv = 1'b1;
    @(negedge clk);
    #1;
    check("R1 release edge1", 64'(step_o), 64'(0));
    check("R1 release edge1 halt", 64'(halt_o), 64'(0));
    @(negedge clk);
    fire = '0; en = '0; adv = 1'b0;
    check_all("R1 after release");

    // R4 R5 R6 R7 R8: exhaustive fire x enable sweep
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        apply(N'(f), N'(e), 1'b1, 1'b0, "R4/R5/R6/R7/R8 sweep");
        if (m_halt) begin
          // R10: blocked advances with other fires while halted
          apply(N'(~f), 4'hF, 1'b1, 1'b0, "R10 hold");
          apply(4'hF, 4'hF, 1'b1, 1'b0, "R10 hold2");
          // R11: clear
          apply('0, '0, 1'b0, 1'b1, "R11 clear");
        end
      end
    end

    // R9: fires without advance
    for (int f = 1; f < 16; f++) apply(N'(f), 4'hF, 1'b0, 1'b0, "R9 no advance");

    // R11: clear while not halted has no effect
    apply('0, '0, 1'b0, 1'b1, "R11 idle clear");
    apply(4'h2, 4'hF, 1'b1, 1'b1, "R11 clear with hit");
    apply('0, '0, 1'b0, 1'b1, "R11 clear2");

    // R2: run counter through wrap
    for (int k = 0; k < 300; k++) apply('0, 4'hF, 1'b1, 1'b0, "R2 wrap");
    apply(4'h8, 4'h8, 1'b1, 1'b0, "R2 R5 after wrap");
    apply('0, '0, 1'b0, 1'b1, "R11 final clear");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule